// File: doc/BRIEF.md
# Parallel-Request Flash Memory Emulator

This block stands in for a small nonvolatile user memory on a chip. It holds 512 words of 16 bits, split into two sectors of 256 words. A requester drives one of three active-low strobes to start an operation: a single-word read, a single-word write, or an erase of a whole sector. While the operation runs, the block holds an active-low busy line. The requester is free to do other work during that time and only has to wait for busy to return high. A read ends with its word on the data output and a data-valid flag raised.

Each kind of operation takes a fixed number of internal clock cycles, and those counts are parameters. Erased words read as all ones. A write can only clear bits, as it does in a real flash cell. The address and data widths seen by the user can be set narrower than the storage. The block then adapts them: the user address fills the top bits of the 9-bit storage address with zeros below it, and the user data fills the top bits of the 16-bit word with ones below it.

Top module: `parflash_emu`

## Requirements
- R1: After reset, busy_n is 1, rd_valid is 0 and every word reads as all ones.
- R2: A request is taken on a clock edge where busy_n is 1, one strobe has just gone from high to low, and that strobe is the only one low. busy_n is 0 from the next cycle on.
- R3: busy_n stays 0 for exactly RD_LAT cycles for a read, WR_LAT cycles for a write and ER_LAT cycles for an erase, and then returns to 1.
- R4: When a read completes, rdata holds the word at the request address and rd_valid is 1. rd_valid stays 1 until the next request is accepted, and it is 0 from the cycle after that acceptance.
- R5: A write stores the bitwise AND of the current word and wdata, so it can clear bits but never set them.
- R6: An erase sets all 256 words of one sector to all ones. Storage address bit 8 equal to 0 selects words 0 to 255, and equal to 1 selects words 256 to 511. The other sector is left unchanged.
- R7: If two or more strobes are low at the same time, nothing is accepted: busy_n stays 1 and no word changes.
- R8: A strobe that falls while busy_n is 0 is ignored. After the current operation, no further operation starts and no word changes.
- R9: With USER_AW below 9, the user address forms the upper bits of the storage address and the lower bits are zero. The top user address bit therefore selects the erase sector, and distinct user addresses reach distinct words.
- R10: With USER_DW below 16, write data lands in the upper bits of the word with ones below it, and rdata returns those same upper bits.
- R11: A strobe held low after its operation completes does not start another operation. A new request needs a fresh falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_rd_n | input | 1 | Read request strobe, active low |
| req_wr_n | input | 1 | Write request strobe, active low |
| req_er_n | input | 1 | Sector erase request strobe, active low |
| addr | input | USER_AW | User word address |
| wdata | input | USER_DW | User write data |
| rdata | output | USER_DW | Read data from the last completed read |
| busy_n | output | 1 | Low while an operation runs |
| rd_valid | output | 1 | High when rdata holds a completed read |

## Verification
The bench counts busy cycles for each kind of operation. A counter off by one would show up here as a latency of LAT±1. It overlaps strobes and pulses a strobe in the middle of an operation. A design that decoded overlapping strobes, or that queued the stray request, would then start an extra operation or change a word.

The bench also holds a strobe low across a completion. A level-sampled design would restart in that case. Repeated writes catch a design that stores the new data instead of ANDing it in. Erases of each sector, checked against a word in the other sector, catch a design that picks the wrong sector or clears both. A narrow instance checks sector choice and address separation through the adapter. A wrong shift there would alias words or erase the wrong half.

// File: rtl/parflash_emu.sv
module parflash_emu #(
  parameter int USER_AW = 9,
  parameter int USER_DW = 16,
  parameter int RD_LAT  = 4,
  parameter int WR_LAT  = 16,
  parameter int ER_LAT  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_rd_n,
  input  logic               req_wr_n,
  input  logic               req_er_n,
  input  logic [USER_AW-1:0] addr,
  input  logic [USER_DW-1:0] wdata,
  output logic [USER_DW-1:0] rdata,
  output logic               busy_n,
  output logic               rd_valid
);
  localparam int FAW   = 9;
  localparam int FDW   = 16;
  localparam int WORDS = 1 << FAW;
  localparam int HALF  = WORDS / 2;
  localparam int MAXL  = (RD_LAT > WR_LAT) ? ((RD_LAT > ER_LAT) ? RD_LAT : ER_LAT)
                                           : ((WR_LAT > ER_LAT) ? WR_LAT : ER_LAT);
  localparam int CW    = $clog2(MAXL + 1) + 1;

  logic [FAW-1:0] addr_full;
  logic [FDW-1:0] data_full;

  generate
    if (USER_AW < FAW) begin : g_apad
      assign addr_full = {addr, {(FAW-USER_AW){1'b0}}};
    end else begin : g_afull
      assign addr_full = addr[FAW-1:0];
    end
    if (USER_DW < FDW) begin : g_dpad
      assign data_full = {wdata, {(FDW-USER_DW){1'b1}}};
    end else begin : g_dfull
      assign data_full = wdata[FDW-1:0];
    end
  endgenerate

  logic [2:0]     req_low, prev_low, fall;
  logic           start, done;
  logic [2:0]     op_q;
  logic [FAW-1:0] addr_q;
  logic [FDW-1:0] data_q, rdata_q, word_now;
  logic [CW-1:0]  cnt;
  logic [FDW-1:0] mem [WORDS];
  logic [WORDS-1:0] live;

  assign req_low  = ~{req_er_n, req_wr_n, req_rd_n};
  assign fall     = req_low & ~prev_low;
  assign start    = busy_n && $onehot(req_low) && (|fall);
  assign done     = !busy_n && (cnt == '0);
  assign word_now = live[addr_q] ? mem[addr_q] : {FDW{1'b1}};
  assign rdata    = rdata_q[FDW-1 -: USER_DW];

  always_ff @(posedge clk) begin
    if (done && op_q[1]) mem[addr_q] <= word_now & data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_low <= '0;
      busy_n   <= 1'b1;
      rd_valid <= 1'b0;
      live     <= '0;
      cnt      <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '1;
      rdata_q  <= '1;
    end else begin
      prev_low <= req_low;
      if (start) begin
        op_q     <= fall;
        addr_q   <= addr_full;
        data_q   <= data_full;
        busy_n   <= 1'b0;
        rd_valid <= 1'b0;
        cnt      <= fall[0] ? CW'(RD_LAT - 1) : fall[1] ? CW'(WR_LAT - 1) : CW'(ER_LAT - 1);
      end else if (done) begin
        busy_n <= 1'b1;
        if (op_q[0]) begin
          rdata_q  <= word_now;
          rd_valid <= 1'b1;
        end
        if (op_q[1]) live[addr_q] <= 1'b1;
        if (op_q[2]) begin
          if (addr_q[FAW-1]) live[WORDS-1:HALF] <= '0;
          else               live[HALF-1:0]     <= '0;
        end
      end else if (!busy_n) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && $countones(req_low) == 1 && (req_low & ~prev_low) != 3'b000) |=> !busy_n);

  assert_multi_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && $countones(req_low) > 1) |=> busy_n);

  assert_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && cnt != '0) |=> !busy_n);

  assert_valid_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy_n);

  assert_rdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> (!busy_n || $stable(rdata) || rd_valid));
endmodule

// File: tb/parflash_emu_bench.sv
`timescale 1ns/1ps
module parflash_emu_bench;
  logic clk = 0;
  logic rst_n = 0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic        rd_n = 1, wr_n = 1, er_n = 1;
  logic [8:0]  a = '0;
  logic [15:0] d = '0;
  logic [15:0] q;
  logic        bsy_n, vld;

  logic        nrd_n = 1, nwr_n = 1, ner_n = 1;
  logic [4:0]  na = '0;
  logic [7:0]  nd = '0;
  logic [7:0]  nq;
  logic        nbsy_n, nvld;

  parflash_emu u_parflash_emu (
    .clk(clk), .rst_n(rst_n), .req_rd_n(rd_n), .req_wr_n(wr_n), .req_er_n(er_n),
    .addr(a), .wdata(d), .rdata(q), .busy_n(bsy_n), .rd_valid(vld));

  parflash_emu #(.USER_AW(5), .USER_DW(8)) u_narrow (
    .clk(clk), .rst_n(rst_n), .req_rd_n(nrd_n), .req_wr_n(nwr_n), .req_er_n(ner_n),
    .addr(na), .wdata(nd), .rdata(nq), .busy_n(nbsy_n), .rd_valid(nvld));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input int kind, input logic [8:0] ad, input logic [15:0] dt, output int cyc);
    @(negedge clk);
    a = ad; d = dt;
    if (kind == 0) rd_n = 0; else if (kind == 1) wr_n = 0; else er_n = 0;
    @(negedge clk);
    rd_n = 1; wr_n = 1; er_n = 1;
    cyc = 0;
    while (!bsy_n && cyc < 1000) begin cyc++; @(negedge clk); end
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] ad, input logic [15:0] exp);
    int c;
    op(0, ad, 16'h0, c);
    chk(tag, q, exp);
  endtask

  task automatic nop(input int kind, input logic [4:0] ad, input logic [7:0] dt);
    int cyc;
    @(negedge clk);
    na = ad; nd = dt;
    if (kind == 0) nrd_n = 0; else if (kind == 1) nwr_n = 0; else ner_n = 0;
    @(negedge clk);
    nrd_n = 1; nwr_n = 1; ner_n = 1;
    cyc = 0;
    while (!nbsy_n && cyc < 1000) begin cyc++; @(negedge clk); end
  endtask

  task automatic t_reset;
    int c;
    chk("R1 busy_n", {15'b0, bsy_n}, 16'h1);
    chk("R1 rd_valid", {15'b0, vld}, 16'h0);
    op(0, 9'h005, 16'h0, c);
    chk("R1 erased word", q, 16'hFFFF);
    chk("R3 read latency", c[15:0], 16'd4);
    chk("R4 valid after read", {15'b0, vld}, 16'h1);
  endtask

  task automatic t_write;
    int c;
    op(1, 9'h005, 16'h12F0, c);
    chk("R3 write latency", c[15:0], 16'd16);
    chk("R4 valid cleared by write", {15'b0, vld}, 16'h0);
    rd_chk("R4 read back", 9'h005, 16'h12F0);
    op(1, 9'h005, 16'hFF0F, c);
    rd_chk("R5 and-write", 9'h005, 16'h1200);
    op(1, 9'h105, 16'h0A0A, c);
    rd_chk("R4 sector1 word", 9'h105, 16'h0A0A);
  endtask

  task automatic t_valid_clear;
    @(negedge clk);
    chk("R4 valid held idle", {15'b0, vld}, 16'h1);
    a = 9'h105; rd_n = 0;
    @(negedge clk);
    rd_n = 1;
    chk("R2 busy after accept", {15'b0, bsy_n}, 16'h0);
    chk("R4 valid cleared on accept", {15'b0, vld}, 16'h0);
    while (!bsy_n) @(negedge clk);
  endtask

  task automatic t_erase;
    int c;
    op(2, 9'h000, 16'h0, c);
    chk("R3 erase latency", c[15:0], 16'd64);
    rd_chk("R6 sector0 erased", 9'h005, 16'hFFFF);
    rd_chk("R6 sector1 kept", 9'h105, 16'h0A0A);
    op(2, 9'h1FF, 16'h0, c);
    rd_chk("R6 sector1 erased", 9'h105, 16'hFFFF);
  endtask

  task automatic t_multi;
    int c;
    op(1, 9'h010, 16'h5555, c);
    @(negedge clk);
    a = 9'h010; d = 16'h0000; rd_n = 0; wr_n = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R7 rd+wr dropped", {15'b0, bsy_n}, 16'h1);
    end
    rd_n = 1; wr_n = 1;
    @(negedge clk);
    a = 9'h010; wr_n = 0; er_n = 0;
    @(negedge clk);
    chk("R7 wr+er dropped", {15'b0, bsy_n}, 16'h1);
    wr_n = 1; er_n = 1;
    @(negedge clk);
    chk("R7 still idle", {15'b0, bsy_n}, 16'h1);
    rd_chk("R7 word unchanged", 9'h010, 16'h5555);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    a = 9'h020; d = 16'h00FF; wr_n = 0;
    @(negedge clk);
    wr_n = 1;
    repeat (2) @(negedge clk);
    a = 9'h020; er_n = 0;
    @(negedge clk);
    er_n = 1;
    while (!bsy_n) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk("R8 no queued op", {15'b0, bsy_n}, 16'h1);
    end
    rd_chk("R8 word not erased", 9'h020, 16'h00FF);
  endtask

  task automatic t_held;
    int c;
    @(negedge clk);
    a = 9'h020; rd_n = 0;
    c = 0;
    @(negedge clk);
    while (!bsy_n && c < 100) begin c++; @(negedge clk); end
    chk("R3 held read latency", c[15:0], 16'd4);
    repeat (5) begin
      @(negedge clk);
      chk("R11 no retrigger", {15'b0, bsy_n}, 16'h1);
    end
    rd_n = 1;
    @(negedge clk);
  endtask

  task automatic t_narrow;
    nop(1, 5'b10000, 8'h3C);
    nop(2, 5'b00000, 8'h00);
    nop(0, 5'b10000, 8'h00);
    chk("R9 msb picks sector", {8'h0, nq}, 16'h003C);
    nop(1, 5'b00001, 8'hF0);
    nop(0, 5'b00000, 8'h00);
    chk("R9 distinct words", {8'h0, nq}, 16'h00FF);
    nop(0, 5'b00001, 8'h00);
    chk("R10 narrow readback", {8'h0, nq}, 16'h00F0);
    nop(1, 5'b00010, 8'hA5);
    nop(0, 5'b00010, 8'h00);
    chk("R10 narrow data", {8'h0, nq}, 16'h00A5);
    nop(2, 5'b10000, 8'h00);
    nop(0, 5'b10000, 8'h00);
    chk("R9 sector1 erased", {8'h0, nq}, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_valid_clear();
    t_erase();
    t_multi();
    t_busy_ignore();
    t_held();
    t_narrow();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule